// File: doc/BRIEF.md
# Conditional Data-Processing ALU

This block carries out the sixteen data-processing operations of a 32-bit RISC integer core. Each operation first passes a condition test. The test compares a 4-bit condition code with the N, Z, C and V flags that the block holds. Operations that pass produce a result and a register-write strobe. When the set-flags bit is high, they also update the flags. Operations that fail leave every output as it was.

The block receives the first operand and the shifter operand, together with the carry-out of the shifter. Instruction fetch, the register file and the barrel shifter are outside the block. The subtract forms are built as one operand plus the inverse of the other plus one. The carry-using variants add the current C flag in place of the constant one. Results, the write strobe and the flags are registered and appear one clock after the operation is presented.

Top module: `dp_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released, `result_o`, `wr_en_o` and `flags_o` are all zero. `flags_o` is ordered {N,Z,C,V}, with N in bit 3.
- R2: Condition codes (`cond_i`) pass as follows:
  - 0 when Z=1; 1 when Z=0
  - 2 when C=1; 3 when C=0
  - 4 when N=1; 5 when N=0
  - 6 when V=1; 7 when V=0
  - 8 when C=1 and Z=0; 9 when C=0 or Z=1
  - 10 when N=V; 11 when N!=V
  - 12 when Z=0 and N=V; 13 when Z=1 or N!=V
  - 14 and 15 always.
- R3: If the condition fails, on the next cycle `wr_en_o` is 0, and `result_o` and `flags_o` are unchanged, even with set-flags high.
- R4: The logical opcodes give the following results:
  - 0 gives a AND b; 1 gives a XOR b
  - 12 gives a OR b; 13 gives b
  - 14 gives a AND NOT b; 15 gives NOT b.
- R5: The arithmetic opcodes give the following results:
  - 4 gives a+b; 5 gives a+b+C
  - 2 gives a+~b+1; 6 gives a+~b+C
  - 3 gives b+~a+1; 7 gives b+~a+C.
- R6: Opcodes 8 (AND test), 9 (XOR test), 10 (subtract compare) and 11 (add compare) never raise `wr_en_o` and leave `result_o` unchanged, but they update the flags when set-flags is high.
- R7: With `set_flags_i` low, an executed operation writes its result and leaves `flags_o` unchanged.
- R8: For a logical or test-logical opcode with set-flags high:
  - N is result bit 31, and Z is 1 if the result is zero;
  - C takes `shift_carry_i`;
  - V is unchanged.
- R9: For an arithmetic or compare opcode with set-flags high:
  - N and Z follow the result;
  - C is the carry out of bit 31 of the sum;
  - V is 1 when the two summed terms share a sign that differs from the sign of the result.
- R10: Outputs update exactly one clock after a valid operation. With `valid_i` low, `wr_en_o` is 0 next cycle and `result_o` and `flags_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| cond_i | input | 4 | Condition code |
| opcode_i | input | 4 | Data-processing opcode |
| set_flags_i | input | 1 | Update flags when high |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Shifter operand |
| shift_carry_i | input | 1 | Shifter carry-out |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Destination register write strobe |
| flags_o | output | 4 | Current flags {N,Z,C,V} |

## Verification
Every result, the write strobe and the flags are due on the first rising edge after the operation is presented, with no extra stage. The bench drives each operation on a falling edge. It compares all three outputs on the following falling edge, which falls after exactly one rising edge, and only then drives the next operation. Because the flags carry from one operation to the next, the expected carry and overflow inputs of each vector come from the flags left by the vector before it.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } dp_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_HS = 4'd2,  CC_LO = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    function automatic logic op_is_arith(input logic [3:0] op);
        return (op >= 4'd2 && op <= 4'd7) || op == 4'd10 || op == 4'd11;
    endfunction

    function automatic logic op_is_test(input logic [3:0] op);
        return op[3:2] == 2'b10;
    endfunction

endpackage

// File: rtl/dp_alu_cond.sv
module dp_alu_cond
    import dp_alu_pkg::*;
(
    input  logic [3:0] cond_i,
    input  nzcv_t      flags_i,
    output logic       pass_o
);
    always_comb begin
        unique case (cond_e'(cond_i))
            CC_EQ: pass_o = flags_i.z;
            CC_NE: pass_o = !flags_i.z;
            CC_HS: pass_o = flags_i.c;
            CC_LO: pass_o = !flags_i.c;
            CC_MI: pass_o = flags_i.n;
            CC_PL: pass_o = !flags_i.n;
            CC_VS: pass_o = flags_i.v;
            CC_VC: pass_o = !flags_i.v;
            CC_HI: pass_o = flags_i.c && !flags_i.z;
            CC_LS: pass_o = !flags_i.c || flags_i.z;
            CC_GE: pass_o = flags_i.n == flags_i.v;
            CC_LT: pass_o = flags_i.n != flags_i.v;
            CC_GT: pass_o = !flags_i.z && (flags_i.n == flags_i.v);
            CC_LE: pass_o = flags_i.z || (flags_i.n != flags_i.v);
            default: pass_o = 1'b1;
        endcase
    end

    always_comb begin
        if (cond_i[3:1] == 3'b111) begin
            AST_ALWAYS_PASSES: assert (pass_o) else $error("always-code failed"); // R2
        end
    end
endmodule

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        opcode_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              ovf_o
);
    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] x_d, y_d;
    logic              ci_d;
    logic [SUM_W-1:0]  wide_d;

    always_comb begin
        x_d  = a_i;
        y_d  = b_i;
        ci_d = 1'b0;
        unique case (dp_op_e'(opcode_i))
            OP_SUB, OP_CMP: begin y_d = ~b_i; ci_d = 1'b1; end
            OP_RSB:         begin x_d = b_i; y_d = ~a_i; ci_d = 1'b1; end
            OP_ADC:         ci_d = c_i;
            OP_SBC:         begin y_d = ~b_i; ci_d = c_i; end
            OP_RSC:         begin x_d = b_i; y_d = ~a_i; ci_d = c_i; end
            default:        ci_d = 1'b0;
        endcase
        wide_d = {1'b0, x_d} + {1'b0, y_d} + {{DATA_W{1'b0}}, ci_d};
        sum_o  = wide_d[DATA_W-1:0];
        cout_o = wide_d[DATA_W];
        ovf_o  = (x_d[DATA_W-1] == y_d[DATA_W-1]) && (sum_o[DATA_W-1] != x_d[DATA_W-1]);
    end
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        opcode_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    always_comb begin
        unique case (dp_op_e'(opcode_i))
            OP_AND, OP_TST: res_o = a_i & b_i;
            OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_MOV:         res_o = b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MVN:         res_o = ~b_i;
            default:        res_o = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        cond_i,
    input  logic [3:0]        opcode_i,
    input  logic              set_flags_i,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic              shift_carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [3:0]        flags_o
);
    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              wr;
        nzcv_t             flags;
    } state_t;

    state_t state_d, state_q;

    logic              pass;
    logic [DATA_W-1:0] arith_sum, logic_res, value;
    logic              arith_cout, arith_ovf, is_arith;

    dp_alu_cond u_cond (
        .cond_i  (cond_i),
        .flags_i (state_q.flags),
        .pass_o  (pass)
    );

    dp_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .opcode_i (opcode_i),
        .a_i      (op_a_i),
        .b_i      (op_b_i),
        .c_i      (state_q.flags.c),
        .sum_o    (arith_sum),
        .cout_o   (arith_cout),
        .ovf_o    (arith_ovf)
    );

    dp_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .opcode_i (opcode_i),
        .a_i      (op_a_i),
        .b_i      (op_b_i),
        .res_o    (logic_res)
    );

    always_comb begin
        is_arith = op_is_arith(opcode_i);
        value    = is_arith ? arith_sum : logic_res;
        state_d    = state_q;
        state_d.wr = 1'b0;
        if (valid_i && pass) begin
            if (!op_is_test(opcode_i)) begin
                state_d.result = value;
                state_d.wr     = 1'b1;
            end
            if (set_flags_i) begin
                state_d.flags.n = value[MSB];
                state_d.flags.z = (value == '0);
                if (is_arith) begin
                    state_d.flags.c = arith_cout;
                    state_d.flags.v = arith_ovf;
                end else begin
                    state_d.flags.c = shift_carry_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result_o = state_q.result;
    assign wr_en_o  = state_q.wr;
    assign flags_o  = state_q.flags;

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && opcode_i[3:2] == 2'b10 |=> !wr_en_o && $stable(result_o)) // R6
        else $error("test opcode wrote");
    AST_NO_S_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !set_flags_i |=> $stable(flags_o)) // R7
        else $error("flags moved without set-flags");
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !wr_en_o && $stable(result_o) && $stable(flags_o)) // R10
        else $error("idle cycle changed state");
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !pass |=> !wr_en_o && $stable(result_o) && $stable(flags_o)) // R3
        else $error("failed condition had effect");
    AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !op_is_arith(opcode_i) |=> $stable(flags_o[0])) // R8
        else $error("logical op changed V");
    AST_ALWAYS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && cond_i == 4'd14 && opcode_i[3:2] != 2'b10 |=> wr_en_o) // R2
        else $error("always-code op did not write");
endmodule

// File: tb/dp_alu_tb.sv
module dp_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  cond_i = 4'd14;
    logic [3:0]  opcode_i = 4'd0;
    logic        set_flags_i = 1'b0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic        shift_carry_i = 1'b0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dp_alu u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cond_i(cond_i),
        .opcode_i(opcode_i), .set_flags_i(set_flags_i), .op_a_i(op_a_i),
        .op_b_i(op_b_i), .shift_carry_i(shift_carry_i), .result_o(result_o),
        .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        sc;
        logic [31:0] res;
        logic        we;
        logic [3:0]  fl;
    } vec_t;

    // All run with always-code and set-flags; flags carry from row to row.
    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{4'd4,  32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h80000000, 1'b1, 4'b1001}, // R5 R9 ADD overflow
        '{4'd5,  32'hFFFFFFFF, 32'h00000000, 1'b0, 32'hFFFFFFFF, 1'b1, 4'b1000}, // R5 ADC C=0
        '{4'd2,  32'h00000005, 32'h00000005, 1'b0, 32'h00000000, 1'b1, 4'b0110}, // R5 R9 SUB zero
        '{4'd5,  32'h00000001, 32'h00000002, 1'b0, 32'h00000004, 1'b1, 4'b0000}, // R5 ADC C=1
        '{4'd2,  32'h00000003, 32'h00000005, 1'b0, 32'hFFFFFFFE, 1'b1, 4'b1000}, // R5 SUB borrow
        '{4'd3,  32'h00000003, 32'h00000005, 1'b0, 32'h00000002, 1'b1, 4'b0010}, // R5 RSB
        '{4'd6,  32'h0000000A, 32'h00000003, 1'b0, 32'h00000007, 1'b1, 4'b0010}, // R5 SBC C=1
        '{4'd7,  32'h00000003, 32'h0000000A, 1'b0, 32'h00000007, 1'b1, 4'b0010}, // R5 RSC C=1
        '{4'd2,  32'h00000000, 32'h00000001, 1'b0, 32'hFFFFFFFF, 1'b1, 4'b1000}, // R5 SUB neg
        '{4'd6,  32'h0000000A, 32'h00000003, 1'b0, 32'h00000006, 1'b1, 4'b0010}, // R5 SBC C=0
        '{4'd2,  32'h80000000, 32'h00000001, 1'b0, 32'h7FFFFFFF, 1'b1, 4'b0011}, // R9 SUB overflow
        '{4'd0,  32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 32'hF000F000, 1'b1, 4'b1001}, // R4 R8 AND
        '{4'd1,  32'hFFFF0000, 32'hFFFF0000, 1'b1, 32'h00000000, 1'b1, 4'b0111}, // R4 R8 EOR
        '{4'd12, 32'h00000012, 32'h00003400, 1'b0, 32'h00003412, 1'b1, 4'b0001}, // R4 ORR
        '{4'd13, 32'h0000DEAD, 32'h80000001, 1'b1, 32'h80000001, 1'b1, 4'b1011}, // R4 MOV
        '{4'd14, 32'hFFFFFFFF, 32'h0000FFFF, 1'b0, 32'hFFFF0000, 1'b1, 4'b1001}, // R4 BIC
        '{4'd15, 32'h00000000, 32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b1, 4'b0111}, // R4 MVN
        '{4'd10, 32'h00000001, 32'h00000001, 1'b0, 32'h00000000, 1'b0, 4'b0110}, // R6 CMP
        '{4'd11, 32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h00000000, 1'b0, 4'b1001}, // R6 CMN
        '{4'd8,  32'h000000F0, 32'h0000000F, 1'b1, 32'h00000000, 1'b0, 4'b0111}, // R6 TST
        '{4'd9,  32'h00000005, 32'h00000004, 1'b0, 32'h00000000, 1'b0, 4'b0001}  // R6 TEQ
    };

    task automatic chk(input string tag, input logic [31:0] er, input logic ew, input logic [3:0] ef);
        checks++;
        if (result_o !== er || wr_en_o !== ew || flags_o !== ef) begin
            errors++;
            $display("FAIL %s: got res=%h we=%b fl=%b, expected res=%h we=%b fl=%b",
                     tag, result_o, wr_en_o, flags_o, er, ew, ef);
        end
    endtask

    // Drive on a falling edge, return on the next falling edge (one rising edge later).
    task automatic issue(input logic v, input logic [3:0] c, input logic [3:0] op, input logic s,
                         input logic [31:0] a, input logic [31:0] b, input logic sc);
        valid_i = v; cond_i = c; opcode_i = op; set_flags_i = s;
        op_a_i = a; op_b_i = b; shift_carry_i = sc;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v, r;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c[3:1])
            3'd0: r = z;
            3'd1: r = cy;
            3'd2: r = n;
            3'd3: r = v;
            3'd4: r = cy & ~z;
            3'd5: r = (n == v);
            3'd6: r = ~z & (n == v);
            default: r = 1'b1;
        endcase
        if (c[3:1] != 3'd7 && c[0]) r = ~r;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] prev_res;
        logic [3:0]  st_fl;
        @(negedge clk);
        chk("R1 in reset", 32'h0, 1'b0, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'h0, 1'b0, 4'h0);

        for (int i = 0; i < NV; i++) begin
            issue(1'b1, 4'd14, VEC[i].op, 1'b1, VEC[i].a, VEC[i].b, VEC[i].sc);
            chk($sformatf("R4/R5/R6/R8/R9 vector %0d", i), VEC[i].res, VEC[i].we, VEC[i].fl);
        end

        // R7: no flag update without set-flags
        issue(1'b1, 4'd14, 4'd4, 1'b0, 32'd1, 32'd1, 1'b0);
        chk("R7 ADD S=0", 32'd2, 1'b1, 4'b0001);
        issue(1'b1, 4'd14, 4'd10, 1'b0, 32'd0, 32'd1, 1'b0);
        chk("R7 CMP S=0", 32'd2, 1'b0, 4'b0001);

        // R10: idle cycle has no effect
        issue(1'b0, 4'd14, 4'd13, 1'b1, 32'd0, 32'd0, 1'b1);
        chk("R10 valid low", 32'd2, 1'b0, 4'b0001);

        // R3: failed condition with set-flags high (EQ with Z=0)
        issue(1'b1, 4'd0, 4'd13, 1'b1, 32'd0, 32'd0, 1'b1);
        chk("R3 failed cond S=1", 32'd2, 1'b0, 4'b0001);

        // R2/R3: every condition over several flag states
        prev_res = 32'd2;
        for (int k = 0; k < 5; k++) begin
            case (k)
                0: begin issue(1'b1, 4'd14, 4'd4, 1'b1, 32'd1, 32'd1, 1'b0); st_fl = 4'b0000; prev_res = 32'd2; end
                1: begin issue(1'b1, 4'd14, 4'd2, 1'b1, 32'd5, 32'd5, 1'b0); st_fl = 4'b0110; prev_res = 32'd0; end
                2: begin issue(1'b1, 4'd14, 4'd4, 1'b1, 32'h7FFFFFFF, 32'd1, 1'b0); st_fl = 4'b1001; prev_res = 32'h80000000; end
                3: begin issue(1'b1, 4'd14, 4'd2, 1'b1, 32'h80000000, 32'd1, 1'b0); st_fl = 4'b0011; prev_res = 32'h7FFFFFFF; end
                default: begin issue(1'b1, 4'd14, 4'd2, 1'b1, 32'd0, 32'd1, 1'b0); st_fl = 4'b1000; prev_res = 32'hFFFFFFFF; end
            endcase
            chk($sformatf("R9 flag setup %0d", k), prev_res, 1'b1, st_fl);
            for (int c = 0; c < 16; c++) begin
                logic ok;
                ok = cond_ok(4'(c), st_fl);
                issue(1'b1, 4'(c), 4'd13, 1'b0, 32'd0, 32'd100 + 32'(c), 1'b0);
                if (ok) prev_res = 32'd100 + 32'(c);
                chk($sformatf("R2 R3 cond %0d flags %b", c, st_fl), prev_res, ok, st_fl);
            end
        end

        // R1: reset in mid-run
        rst_n = 1'b0;
        #1;
        chk("R1 async reset", 32'h0, 1'b0, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        issue(1'b1, 4'd14, 4'd13, 1'b1, 32'd0, 32'h0000ABCD, 1'b1);
        chk("R10 first op after reset", 32'h0000ABCD, 1'b1, 4'b0010);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule